// File: doc/BRIEF.md
# Nibble-Wide Ethernet Receive Framer

This block sits behind a media-independent receive interface that delivers one 4-bit nibble per clock, qualified by a data-valid line. It looks for the run of preamble nibbles and the start delimiter that open a frame. It then pairs nibbles into bytes and hands each byte to a receive buffer through a simple write strobe. While bytes stream by, it checks the frame against several rules. The frame must follow a long enough idle gap. Its destination address must be the station's own address or broadcast. Its length must lie within bounds. Its CRC must come out right.

When the data-valid line drops, the block pulses a one-cycle end strobe together with a pass/fail flag. The buffer uses that flag to keep or discard what it has just stored. A frame that fails the gap rule, or a burst with a malformed opening, writes nothing at all. An oversize frame stops writing once the byte limit is reached and the rest of it is ignored.

Top module: `mii_rx_framer`

## Requirements
- R1: After a synchronous active-high reset, `wr_en`, `frame_done` and `frame_ok` are all low.
- R2: A frame opens with one or more nibbles of value 0x5 followed by a nibble 0xD. Any other nibble during that opening, or a first nibble other than 0x5, makes the block ignore the whole burst: no byte writes and no end strobe.
- R3: Each byte is built from two nibbles, the first received nibble as bits [3:0] and the second as bits [7:4]. `wr_en` pulses for one cycle with the byte on `wr_data` in the cycle after its second nibble is sampled, and bytes are written in arrival order.
- R4: A frame is accepted only if `rx_dv` was sampled low for at least MIN_GAP (default 24) clock cycles since the previous burst; reset counts as a long enough gap. A frame that violates this writes no bytes and ends with `frame_ok` low.
- R5: Received byte i (i = 0..5) is compared with `station_addr[8i+7:8i]`. A frame passes the address check when all six bytes match, or when all six are 0xFF (broadcast).
- R6: The byte count runs from the first destination byte through the last FCS byte. A frame passes only with a count from MIN_LEN (64) to MAX_LEN (1518) inclusive.
- R7: Once MAX_LEN bytes have been written, no further byte of that frame is written, and the frame ends with `frame_ok` low.
- R8: The CRC runs over every byte after the delimiter, FCS included, least significant bit first, starting from all ones with the reflected polynomial. It passes when the final register, bit-reversed, equals 0xC704DD7B.
- R9: For a frame whose delimiter was seen, `frame_done` pulses for exactly one cycle, one cycle after `rx_dv` is first sampled low. `frame_ok` is high only with that pulse, and only when R4, R5, R6 and R8 all pass.
- R10: A frame that ends after an odd number of data nibbles ends with `frame_ok` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one nibble per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_dv | input | 1 | Nibble valid from the line interface |
| rxd | input | 4 | Received nibble |
| station_addr | input | 48 | Own address; byte i in bits [8i+7:8i] |
| wr_en | output | 1 | Byte write strobe to the receive buffer |
| wr_data | output | 8 | Assembled byte |
| frame_done | output | 1 | One-cycle end-of-frame strobe |
| frame_ok | output | 1 | Frame passed every check, valid with frame_done |

## Verification
On every cycle, the assertions check the following. The status flag never appears without the end strobe, and the strobe never lasts two cycles. No write follows the idle or drop states, and the write count never passes the length limit. Any valid nibble clears the gap qualification. Clearing the CRC or address trackers leaves them in their known starting states. The remaining behaviours can only be shown by the bench's scenarios: the correct byte order and content, the acceptance decision for each combination of address, length, gap and CRC, and the absence of any strobe after a malformed opening.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SFD,
    S_LO,
    S_HI,
    S_DROP
  } rx_state_t;

  localparam logic [3:0]  PRE_NIB     = 4'h5;
  localparam logic [3:0]  SFD_NIB     = 4'hD;
  localparam logic [31:0] CRC_POLY_RF = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE = 32'hC704DD7B;
  localparam int          DA_BYTES    = 6;

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

endpackage

// File: rtl/rx_crc4.sv
module rx_crc4
  import mii_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [3:0] nib,
  output logic       good
);
  localparam logic [31:0] RES_RF = rev32(CRC_RESIDUE);

  logic [31:0] c, nxt;

  always_comb begin
    nxt = c;
    for (int i = 0; i < 4; i++) begin
      if (nxt[0] ^ nib[i]) nxt = {1'b0, nxt[31:1]} ^ CRC_POLY_RF;
      else                 nxt = {1'b0, nxt[31:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) c <= '1;
    else if (en)    c <= nxt;
  end

  assign good = (c == RES_RF);

  AST_CRC_CLEAR_NOT_GOOD: assert property (@(posedge clk) disable iff (rst) clr |=> !good); // R8

endmodule

// File: rtl/rx_gap_timer.sv
module rx_gap_timer #(
  parameter int MIN_GAP = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_dv,
  output logic gap_met
);
  localparam int GW = $clog2(MIN_GAP + 1);
  localparam logic [GW-1:0] GAP_C = GW'(MIN_GAP);

  logic [GW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= GAP_C;
    else if (rx_dv)          cnt <= '0;
    else if (cnt != GAP_C)   cnt <= cnt + 1'b1;
  end

  assign gap_met = (cnt == GAP_C);

  AST_GAP_RESTART: assert property (@(posedge clk) disable iff (rst) rx_dv |=> !gap_met); // R4

endmodule

// File: rtl/rx_addr_match.sv
module rx_addr_match
  import mii_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        stb,
  input  logic [2:0]  idx,
  input  logic [7:0]  data,
  input  logic [47:0] station_addr,
  output logic        hit
);
  logic uni_ok, bc_ok;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      uni_ok <= 1'b1;
      bc_ok  <= 1'b1;
    end else if (stb) begin
      if (data != station_addr[{idx, 3'b000} +: 8]) uni_ok <= 1'b0;
      if (data != 8'hFF)                           bc_ok  <= 1'b0;
    end
  end

  assign hit = uni_ok | bc_ok;

  AST_ADDR_CLEAR_HIT: assert property (@(posedge clk) disable iff (rst) clr |=> hit); // R5

endmodule

// File: rtl/mii_rx_framer.sv
module mii_rx_framer
  import mii_rx_pkg::*;
#(
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518,
  parameter int MIN_GAP = 24
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_dv,
  input  logic [3:0]  rxd,
  input  logic [47:0] station_addr,
  output logic        wr_en,
  output logic [7:0]  wr_data,
  output logic        frame_done,
  output logic        frame_ok
);
  localparam int CW = $clog2(MAX_LEN + 2);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_LEN);
  localparam logic [CW-1:0] MIN_C = CW'(MIN_LEN);
  localparam logic [CW-1:0] DA_C  = CW'(DA_BYTES);

  rx_state_t     state;
  logic [3:0]    lo_nib;
  logic [CW-1:0] byte_cnt;
  logic          gap_q, in_frame;
  logic          gap_met, crc_good, addr_hit;

  rx_gap_timer #(.MIN_GAP(MIN_GAP)) u_gap (
    .clk(clk), .rst(rst), .rx_dv(rx_dv), .gap_met(gap_met)
  );

  rx_crc4 u_crc (
    .clk(clk), .rst(rst), .clr(state == S_IDLE),
    .en(rx_dv && (state == S_LO || state == S_HI)),
    .nib(rxd), .good(crc_good)
  );

  rx_addr_match u_addr (
    .clk(clk), .rst(rst), .clr(state == S_IDLE),
    .stb(rx_dv && state == S_HI && byte_cnt < DA_C),
    .idx(byte_cnt[2:0]), .data({rxd, lo_nib}),
    .station_addr(station_addr), .hit(addr_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      lo_nib     <= '0;
      byte_cnt   <= '0;
      gap_q      <= 1'b0;
      in_frame   <= 1'b0;
      wr_en      <= 1'b0;
      wr_data    <= '0;
      frame_done <= 1'b0;
      frame_ok   <= 1'b0;
    end else begin
      wr_en      <= 1'b0;
      frame_done <= 1'b0;
      frame_ok   <= 1'b0;
      case (state)
        S_IDLE: begin
          byte_cnt <= '0;
          in_frame <= 1'b0;
          if (rx_dv) begin
            if (rxd == PRE_NIB) begin
              state <= S_SFD;
              gap_q <= gap_met;
            end else begin
              state <= S_DROP;
            end
          end
        end
        S_SFD: begin
          if (!rx_dv) state <= S_IDLE;
          else if (rxd == SFD_NIB) begin
            in_frame <= 1'b1;
            state    <= gap_q ? S_LO : S_DROP;
          end else if (rxd != PRE_NIB) state <= S_DROP;
        end
        S_LO: begin
          if (!rx_dv) begin
            state      <= S_IDLE;
            frame_done <= 1'b1;
            frame_ok   <= crc_good && addr_hit && (byte_cnt >= MIN_C);
          end else begin
            lo_nib <= rxd;
            state  <= S_HI;
          end
        end
        S_HI: begin
          if (!rx_dv) begin
            state      <= S_IDLE;
            frame_done <= 1'b1;
          end else if (byte_cnt >= MAX_C) begin
            state <= S_DROP;
          end else begin
            wr_en    <= 1'b1;
            wr_data  <= {rxd, lo_nib};
            byte_cnt <= byte_cnt + 1'b1;
            state    <= S_LO;
          end
        end
        S_DROP: begin
          if (!rx_dv) begin
            state      <= S_IDLE;
            frame_done <= in_frame;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_OK_NEEDS_DONE:     assert property (@(posedge clk) disable iff (rst) frame_ok |-> frame_done); // R9
  AST_DONE_SINGLE:       assert property (@(posedge clk) disable iff (rst) frame_done |=> !frame_done); // R9
  AST_NO_WRITE_IN_DROP:  assert property (@(posedge clk) disable iff (rst) (state == S_DROP) |=> !wr_en); // R7
  AST_NO_WRITE_FROM_IDLE: assert property (@(posedge clk) disable iff (rst) (state == S_IDLE) |=> !wr_en); // R2
  AST_WRITE_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (rst) wr_en |-> (byte_cnt <= MAX_C)); // R7

endmodule

// File: tb/tb_mii_rx_framer.sv
module tb_mii_rx_framer;
  localparam int MIN_LEN = 64;
  localparam int MAX_LEN = 1518;
  localparam int MIN_GAP = 24;
  localparam logic [47:0] STA = 48'h0A1B2C3D4E5F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_dv = 1'b0;
  logic [3:0]  rxd = 4'h0;
  logic        wr_en, frame_done, frame_ok;
  logic [7:0]  wr_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] frm [0:1599];
  logic [7:0] cap [0:1599];
  int ncap = 0;

  always #10 clk = ~clk;

  mii_rx_framer #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .MIN_GAP(MIN_GAP)) dut (
    .clk(clk), .rst(rst), .rx_dv(rx_dv), .rxd(rxd), .station_addr(STA),
    .wr_en(wr_en), .wr_data(wr_data), .frame_done(frame_done), .frame_ok(frame_ok)
  );

  always @(negedge clk) begin
    if (wr_en && ncap < 1600) begin
      cap[ncap] = wr_data;
      ncap = ncap + 1;
    end
  end

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_calc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        if (c[0] ^ frm[i][b]) c = {1'b0, c[31:1]} ^ 32'hEDB88320;
        else                  c = {1'b0, c[31:1]};
      end
    end
    return ~c;
  endfunction

  // kind: 0 own address, 1 broadcast, 2 foreign address
  task automatic build(input int len, input int kind);
    logic [31:0] f;
    for (int i = 0; i < len; i++) frm[i] = 8'($urandom);
    for (int i = 0; i < 6; i++) begin
      case (kind)
        0: frm[i] = STA[8*i +: 8];
        1: frm[i] = 8'hFF;
        default: frm[i] = STA[8*i +: 8] ^ ((i == 2) ? 8'h10 : 8'h00);
      endcase
    end
    f = crc_calc(len - 4);
    for (int k = 0; k < 4; k++) frm[len-4+k] = f[8*k +: 8];
  endtask

  task automatic nib(input logic [3:0] v);
    rx_dv = 1'b1;
    rxd   = v;
    @(negedge clk);
  endtask

  // sends frm[0..len-1]; caller is at a negedge with rx_dv low
  task automatic send(input int len, input int gap, input bit extra_nib, input bit bad_sfd,
                      input bit exp_done, input bit exp_ok, input int exp_wr, input string tag);
    int n;
    repeat (gap - 1) @(negedge clk);
    ncap = 0;
    for (int i = 0; i < 15; i++) nib(4'h5);
    nib(bad_sfd ? 4'h3 : 4'hD);
    for (int i = 0; i < len; i++) begin
      nib(frm[i][3:0]);
      nib(frm[i][7:4]);
    end
    if (extra_nib) nib(4'hA);
    rx_dv = 1'b0;
    rxd   = 4'h0;
    @(negedge clk);
    chk(frame_done == exp_done, {tag, " done"}, int'(frame_done), int'(exp_done));
    chk(frame_ok == exp_ok, {tag, " ok"}, int'(frame_ok), int'(exp_ok));
    chk(ncap == exp_wr, {tag, " R3 write count"}, ncap, exp_wr);
    n = 0;
    for (int i = 0; i < exp_wr && i < ncap; i++) if (cap[i] !== frm[i]) n++;
    chk(n == 0, {tag, " R3 byte content"}, n, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!wr_en && !frame_done && !frame_ok, "R1 reset outputs", int'({wr_en, frame_done, frame_ok}), 0);
    rst = 1'b0;
    @(negedge clk);

    build(64, 0);   send(64, MIN_GAP + 4, 0, 0, 1, 1, 64, "R9 unicast min length");
    build(80, 1);   send(80, MIN_GAP, 0, 0, 1, 1, 80, "R5 broadcast accepted");
    build(64, 2);   send(64, MIN_GAP, 0, 0, 1, 0, 64, "R5 foreign address rejected");
    build(63, 0);   send(63, MIN_GAP, 0, 0, 1, 0, 63, "R6 short frame");
    build(MAX_LEN, 0); send(MAX_LEN, MIN_GAP, 0, 0, 1, 1, MAX_LEN, "R6 max length");
    build(MAX_LEN + 1, 0); send(MAX_LEN + 1, MIN_GAP, 0, 0, 1, 0, MAX_LEN, "R7 oversize drop");
    build(70, 0);   frm[30] = frm[30] ^ 8'h04;
    send(70, MIN_GAP, 0, 0, 1, 0, 70, "R8 corrupted byte");
    build(70, 0);   send(70, MIN_GAP - 1, 0, 0, 1, 0, 0, "R4 gap too short");
    build(70, 0);   send(70, MIN_GAP, 0, 0, 1, 1, 70, "R4 gap exactly minimum");
    build(70, 0);   send(70, MIN_GAP, 0, 1, 0, 0, 0, "R2 bad delimiter");
    build(70, 0);   send(70, MIN_GAP, 1, 0, 1, 0, 70, "R10 odd nibble");

    for (int t = 0; t < 16; t++) begin
      int len, kind;
      bit corrupt, ok;
      len     = $urandom_range(60, 160);
      kind    = $urandom_range(0, 2);
      corrupt = ($urandom_range(0, 3) == 0);
      build(len, kind);
      if (corrupt) frm[len/2] = frm[len/2] ^ 8'h81;
      ok = (kind != 2) && (len >= MIN_LEN) && !corrupt;
      send(len, MIN_GAP + $urandom_range(0, 6), 0, 0, 1, ok, len, "R8 R5 R6 random frame");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule